// File: doc/BRIEF.md
# Reset-Fetch and Fault-Lockup Controller

This block controls the start of a small microcontroller-style core and its severe faults. When reset is released, the core has no valid stack pointer or program counter. The controller reads both values from a vector table in memory through a simple read port. It holds the core stalled until the second word arrives. A debugger can instead write SP and PC while reset is held, then ask for the table fetch to be skipped, so that its own values survive.

Once the core runs, the controller watches what the execute stage reports. An instruction that is attempted with the execution-state bit clear, or that cannot be decoded, is a fault. A fault is taken as a usage fault when that is possible. It is promoted to a hard fault right after reset or inside the usage fault handler. A fault inside the hard fault or NMI handler puts the core into lockup. Lockup is a held state in which the core keeps retrying. It ends when an instruction retires, when an NMI is taken or when reset is applied. Sticky status flags record the kind of each fault.

Top module: `rfl_ctrl`

## Requirements
- R1: No read is requested during reset or in the first cycle after reset is released. The controller then reads address VTAB_BASE and after that VTAB_BASE+DATA_W/8. It holds each address steady with `mem_req` high until `mem_rvalid` returns, and it requests reads only while `core_stall` is high.
- R2: The first word read becomes `sp_init` and the second becomes `pc_init`. `core_stall` falls and `ld_valid` pulses for one cycle in the cycle after the second word is accepted.
- R3: A `dbg_wr` strobe while reset is asserted writes `dbg_sp` and `dbg_pc` into `sp_init` and `pc_init`. If `dbg_keep` is high when reset is released, no read is made, those values are kept, and `core_stall` falls one cycle after release with `ld_valid` pulsing.
- R4: While `core_stall` is high, every execute-stage input and `nmi_req` is ignored. No exception is raised and the status stays unchanged.
- R5: An attempted instruction with `ex_tbit`=0 sets status bit 1 (invalid state). An attempted instruction with `ex_tbit`=1 and `ex_undef`=1 sets status bit 0 (undefined instruction).
- R6: A fault in thread mode after at least one instruction has retired since reset raises exception number 6. `exc_valid` pulses for one cycle in the cycle after the fault.
- R7: A fault in thread mode before any instruction has retired since reset, or a fault inside the usage fault handler, raises exception number 3 and sets status bit 2 (forced).
- R8: A fault inside the hard fault or NMI handler raises `lockup` in the next cycle. No exception is raised, and no exception other than NMI is raised while `lockup` is high.
- R9: `lockup` holds through further faults. It falls in the cycle after an instruction retires, and reset clears it.
- R10: `nmi_req` outside the NMI handler raises exception number 2 and clears `lockup`. It wins over a fault reported in the same cycle. `nmi_req` inside the NMI handler is ignored.
- R11: Status bits are sticky. A `fsr_clr` strobe clears the bits set in `fsr_clr_mask`, and a bit being set in the same cycle stays set.
- R12: `ex_ret` returns the controller to thread mode, so that a later fault is again taken as a usage fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_wr | input | 1 | Debugger write of SP/PC, accepted only during reset |
| dbg_keep | input | 1 | Skip the vector fetch at reset release |
| dbg_sp | input | DATA_W | Debugger stack pointer value |
| dbg_pc | input | DATA_W | Debugger program counter value |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | ADDR_W | Vector read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| core_stall | output | 1 | Core held until SP/PC are loaded |
| ld_valid | output | 1 | One-cycle strobe when SP/PC become valid |
| sp_init | output | DATA_W | Initial stack pointer |
| pc_init | output | DATA_W | Initial program counter, bit 0 is the state bit |
| ex_issue | input | 1 | Execute stage attempts an instruction |
| ex_tbit | input | 1 | State bit of the attempted instruction |
| ex_undef | input | 1 | Attempted instruction is undefined |
| ex_retire | input | 1 | An instruction retired |
| ex_ret | input | 1 | Exception return completed |
| nmi_req | input | 1 | Non-maskable interrupt request |
| fsr_clr | input | 1 | Write-one-to-clear strobe for status |
| fsr_clr_mask | input | 3 | Status bits to clear |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_num | output | EXC_W | Exception number (2, 3 or 6) |
| lockup | output | 1 | Core is locked up |
| fsr | output | 3 | Sticky fault status {forced, invalid state, undefined} |

## Verification
A wrong boot state shows up at once as a read to the wrong address, as SP and PC swapped, or as `core_stall` falling a cycle early or late around the second `mem_rvalid`. A wrong handler-mode state shows up one cycle after the next fault, as the wrong exception number, as a missing or extra forced bit, or as `lockup` failing to rise. A stuck lockup or a lost first-retire flag is only exposed when a retire, an NMI or a fault arrives later, so the stimulus walks every handler mode and then faults again in each one.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
   typedef enum logic [1:0] {
      BOOT_START = 2'd0,
      BOOT_SP    = 2'd1,
      BOOT_PC    = 2'd2,
      BOOT_RUN   = 2'd3
   } boot_st_t;

   typedef enum logic [1:0] {
      ACT_THREAD = 2'd0,
      ACT_USAGE  = 2'd1,
      ACT_HARD   = 2'd2,
      ACT_NMI    = 2'd3
   } act_t;

   localparam int unsigned FLG_UNDEF  = 0;
   localparam int unsigned FLG_INVST  = 1;
   localparam int unsigned FLG_FORCED = 2;
   localparam int unsigned FLG_N      = 3;

   localparam int unsigned EXN_NMI   = 2;
   localparam int unsigned EXN_HARD  = 3;
   localparam int unsigned EXN_USAGE = 6;
endpackage

// File: rtl/rfl_boot_seq.sv
module rfl_boot_seq #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] VTAB_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_wr,
   input  logic              dbg_keep,
   input  logic [DATA_W-1:0] dbg_sp,
   input  logic [DATA_W-1:0] dbg_pc,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              stall,
   output logic              ld_valid,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] pc_q
);
   import rfl_pkg::*;

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] PC_ADDR = VTAB_BASE + ADDR_W'(WORD_BYTES);

   boot_st_t st, st_n;
   logic     ldv_n;

   always_comb begin
      st_n  = st;
      ldv_n = 1'b0;
      unique case (st)
         BOOT_START: begin
            if (dbg_keep) begin
               st_n  = BOOT_RUN;
               ldv_n = 1'b1;
            end else begin
               st_n = BOOT_SP;
            end
         end
         BOOT_SP: if (mem_rvalid) st_n = BOOT_PC;
         BOOT_PC: begin
            if (mem_rvalid) begin
               st_n  = BOOT_RUN;
               ldv_n = 1'b1;
            end
         end
         default: st_n = BOOT_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= BOOT_START;
         ld_valid <= 1'b0;
      end else begin
         st       <= st_n;
         ld_valid <= ldv_n;
      end
   end

   // SP/PC carry no reset value so that a debugger write made during reset survives it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (dbg_wr) begin
            sp_q <= dbg_sp;
            pc_q <= dbg_pc;
         end
      end else if (mem_rvalid && st == BOOT_SP) begin
         sp_q <= mem_rdata;
      end else if (mem_rvalid && st == BOOT_PC) begin
         pc_q <= mem_rdata;
      end
   end

   assign mem_req  = (st == BOOT_SP) || (st == BOOT_PC);
   assign mem_addr = (st == BOOT_PC) ? PC_ADDR : VTAB_BASE;
   assign stall    = (st != BOOT_RUN);

   // R1
   req_in_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> stall);
   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
   // R2
   ld_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> !stall && $past(stall));
endmodule

// File: rtl/rfl_fault_status.sv
module rfl_fault_status #(
   parameter int unsigned NFLG = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NFLG-1:0] set,
   input  logic            clr,
   input  logic [NFLG-1:0] clr_mask,
   output logic [NFLG-1:0] q
);
   for (genvar i = 0; i < NFLG; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                  q[i] <= 1'b0;
         else if (set[i])             q[i] <= 1'b1;
         else if (clr && clr_mask[i]) q[i] <= 1'b0;
      end

      // R11
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         q[i] && !(clr && clr_mask[i]) |=> q[i]);
   end
endmodule

// File: rtl/rfl_fault_fsm.sv
module rfl_fault_fsm #(
   parameter int unsigned EXC_W     = 4,
   parameter bit          ESC_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      ex_issue,
   input  logic                      ex_tbit,
   input  logic                      ex_undef,
   input  logic                      ex_retire,
   input  logic                      ex_ret,
   input  logic                      nmi_req,
   output logic                      exc_valid,
   output logic [EXC_W-1:0]          exc_num,
   output logic                      lockup,
   output logic [rfl_pkg::FLG_N-1:0] flg_set
);
   import rfl_pkg::*;

   localparam logic [EXC_W-1:0] NUM_NMI   = EXC_W'(EXN_NMI);
   localparam logic [EXC_W-1:0] NUM_HARD  = EXC_W'(EXN_HARD);
   localparam logic [EXC_W-1:0] NUM_USAGE = EXC_W'(EXN_USAGE);

   act_t             act, act_n;
   logic             fresh, fresh_n;
   logic             lock_n;
   logic             ev_n;
   logic [EXC_W-1:0] num_n;
   logic             forced;
   logic             fault_now, retire_ok, nmi_take, early_esc;

   assign fault_now = run && ex_issue && (!ex_tbit || ex_undef);
   assign retire_ok = run && ex_retire && !fault_now;
   assign nmi_take  = run && nmi_req && (act != ACT_NMI);

   if (ESC_FIRST) begin : g_esc_first
      assign early_esc = fresh;
   end else begin : g_no_esc_first
      assign early_esc = 1'b0;
   end

   always_comb begin
      act_n   = act;
      fresh_n = fresh;
      lock_n  = lockup;
      ev_n    = 1'b0;
      num_n   = '0;
      forced  = 1'b0;
      if (retire_ok) begin
         fresh_n = 1'b0;
         lock_n  = 1'b0;
      end
      if (run && ex_ret && !lockup) act_n = ACT_THREAD;
      if (nmi_take) begin
         ev_n   = 1'b1;
         num_n  = NUM_NMI;
         act_n  = ACT_NMI;
         lock_n = 1'b0;
      end else if (fault_now && !lockup) begin
         unique case (act)
            ACT_THREAD: begin
               ev_n = 1'b1;
               if (early_esc) begin
                  num_n  = NUM_HARD;
                  act_n  = ACT_HARD;
                  forced = 1'b1;
               end else begin
                  num_n = NUM_USAGE;
                  act_n = ACT_USAGE;
               end
            end
            ACT_USAGE: begin
               ev_n   = 1'b1;
               num_n  = NUM_HARD;
               act_n  = ACT_HARD;
               forced = 1'b1;
            end
            default: lock_n = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act       <= ACT_THREAD;
         fresh     <= 1'b1;
         lockup    <= 1'b0;
         exc_valid <= 1'b0;
         exc_num   <= '0;
      end else begin
         act       <= act_n;
         fresh     <= fresh_n;
         lockup    <= lock_n;
         exc_valid <= ev_n;
         exc_num   <= num_n;
      end
   end

   always_comb begin
      flg_set             = '0;
      flg_set[FLG_UNDEF]  = fault_now && ex_tbit;
      flg_set[FLG_INVST]  = fault_now && !ex_tbit;
      flg_set[FLG_FORCED] = forced;
   end

   // R4
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !exc_valid);
   // R6
   usage_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && exc_num == NUM_USAGE |=> !(exc_valid && exc_num == NUM_USAGE));
   // R8
   lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockup |-> !exc_valid);
   // R9
   lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lockup) |-> $past(ex_retire) || (exc_valid && exc_num == NUM_NMI));
endmodule

// File: rtl/rfl_ctrl.sv
module rfl_ctrl #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] VTAB_BASE = '0,
   parameter int unsigned EXC_W = 4,
   parameter bit ESC_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dbg_wr,
   input  logic                      dbg_keep,
   input  logic [DATA_W-1:0]         dbg_sp,
   input  logic [DATA_W-1:0]         dbg_pc,
   output logic                      mem_req,
   output logic [ADDR_W-1:0]         mem_addr,
   input  logic                      mem_rvalid,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic                      core_stall,
   output logic                      ld_valid,
   output logic [DATA_W-1:0]         sp_init,
   output logic [DATA_W-1:0]         pc_init,
   input  logic                      ex_issue,
   input  logic                      ex_tbit,
   input  logic                      ex_undef,
   input  logic                      ex_retire,
   input  logic                      ex_ret,
   input  logic                      nmi_req,
   input  logic                      fsr_clr,
   input  logic [rfl_pkg::FLG_N-1:0] fsr_clr_mask,
   output logic                      exc_valid,
   output logic [EXC_W-1:0]          exc_num,
   output logic                      lockup,
   output logic [rfl_pkg::FLG_N-1:0] fsr
);
   import rfl_pkg::*;

   localparam int unsigned TAB_ALIGN = 2 * (DATA_W / 8);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("rfl_ctrl: DATA_W must be a whole number of bytes, at least 16");
   end
   if (EXC_W < 3) begin : g_bad_exc_w
      $error("rfl_ctrl: EXC_W too narrow for exception number 6");
   end
   if ((VTAB_BASE % TAB_ALIGN) != 0) begin : g_bad_base
      $error("rfl_ctrl: VTAB_BASE must be aligned to two words");
   end

   logic [FLG_N-1:0] flg_set;

   rfl_boot_seq #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .VTAB_BASE (VTAB_BASE)
   ) u_boot (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbg_wr     (dbg_wr),
      .dbg_keep   (dbg_keep),
      .dbg_sp     (dbg_sp),
      .dbg_pc     (dbg_pc),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .stall      (core_stall),
      .ld_valid   (ld_valid),
      .sp_q       (sp_init),
      .pc_q       (pc_init)
   );

   rfl_fault_fsm #(
      .EXC_W     (EXC_W),
      .ESC_FIRST (ESC_FIRST)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (!core_stall),
      .ex_issue  (ex_issue),
      .ex_tbit   (ex_tbit),
      .ex_undef  (ex_undef),
      .ex_retire (ex_retire),
      .ex_ret    (ex_ret),
      .nmi_req   (nmi_req),
      .exc_valid (exc_valid),
      .exc_num   (exc_num),
      .lockup    (lockup),
      .flg_set   (flg_set)
   );

   rfl_fault_status #(
      .NFLG (FLG_N)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (flg_set),
      .clr      (fsr_clr),
      .clr_mask (fsr_clr_mask),
      .q        (fsr)
   );

   // R4
   boot_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_stall && $past(core_stall) |-> fsr == '0);
endmodule

// File: tb/sim_rfl_ctrl.sv
`timescale 1ns/1ps
module sim_rfl_ctrl;
   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned EW = 4;
   localparam logic [DW-1:0] SP_WORD = 32'h2000_0400;
   localparam logic [DW-1:0] PC_WORD = 32'h0000_0101;
   localparam logic [DW-1:0] DBG_SPV = 32'h2000_1F00;
   localparam logic [DW-1:0] DBG_PCV = 32'h0000_0801;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dbg_wr = 1'b0, dbg_keep = 1'b0;
   logic [DW-1:0] dbg_sp = '0, dbg_pc = '0;
   logic mem_req;
   logic [AW-1:0] mem_addr;
   logic mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic core_stall, ld_valid;
   logic [DW-1:0] sp_init, pc_init;
   logic ex_issue = 1'b0, ex_tbit = 1'b1, ex_undef = 1'b0;
   logic ex_retire = 1'b0, ex_ret = 1'b0, nmi_req = 1'b0;
   logic fsr_clr = 1'b0;
   logic [2:0] fsr_clr_mask = '0;
   logic exc_valid;
   logic [EW-1:0] exc_num;
   logic lockup;
   logic [2:0] fsr;

   int n_vec = 0;
   int n_err = 0;
   int exp_q[$];
   logic [AW-1:0] addr_log[$];
   int req_cycles = 0;
   int mem_cnt = 0;

   always #2.5 clk = ~clk;

   rfl_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .dbg_wr(dbg_wr), .dbg_keep(dbg_keep),
      .dbg_sp(dbg_sp), .dbg_pc(dbg_pc), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .core_stall(core_stall),
      .ld_valid(ld_valid), .sp_init(sp_init), .pc_init(pc_init),
      .ex_issue(ex_issue), .ex_tbit(ex_tbit), .ex_undef(ex_undef),
      .ex_retire(ex_retire), .ex_ret(ex_ret), .nmi_req(nmi_req),
      .fsr_clr(fsr_clr), .fsr_clr_mask(fsr_clr_mask), .exc_valid(exc_valid),
      .exc_num(exc_num), .lockup(lockup), .fsr(fsr)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   endtask

   // memory model: answers each request two cycles later, one word per response
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_cnt = 0;
      end else if (mem_rvalid) begin
         mem_rvalid <= 1'b0;
      end else if (mem_req) begin
         req_cycles++;
         if (mem_cnt == 1) begin
            mem_cnt = 0;
            addr_log.push_back(mem_addr);
            mem_rdata  <= (mem_addr == 32'h0) ? SP_WORD : PC_WORD;
            mem_rvalid <= 1'b1;
         end else begin
            mem_cnt++;
         end
      end
   end

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (rst_n && exc_valid) begin
         n_vec++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R6/R8 unexpected exception actual=%0d expected=none", exc_num);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(exc_num) != e) begin
               n_err++;
               $display("FAIL R6/R7/R10 exception number actual=%0d expected=%0d", exc_num, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   // one cycle of stimulus from a negedge to the next
   task automatic cyc(input logic iss, input logic tb, input logic ud, input logic rt,
                      input logic xr, input logic nm, input logic cl, input logic [2:0] mk);
      ex_issue = iss; ex_tbit = tb; ex_undef = ud; ex_retire = rt;
      ex_ret = xr; nmi_req = nm; fsr_clr = cl; fsr_clr_mask = mk;
      @(negedge clk);
      ex_issue = 1'b0; ex_tbit = 1'b1; ex_undef = 1'b0; ex_retire = 1'b0;
      ex_ret = 1'b0; nmi_req = 1'b0; fsr_clr = 1'b0; fsr_clr_mask = '0;
   endtask

   task automatic flt(input logic tb, input logic ud);
      cyc(1'b1, tb, ud, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
   endtask

   initial begin
      int guard;
      repeat (3) @(negedge clk);
      chk("R1 no request in reset", mem_req, 1'b0);
      chk("R2 stall in reset", core_stall, 1'b1);
      chk("R9 no lockup at reset", lockup, 1'b0);
      chk("R11 status clear at reset", fsr, 3'b000);

      // release; hammer fault and NMI while stalled (R4)
      rst_n = 1'b1;
      chk("R1 no request first cycle", mem_req, 1'b0);
      ex_issue = 1'b1; ex_tbit = 1'b0; nmi_req = 1'b1;
      guard = 0;
      while (core_stall && guard < 50) begin
         @(negedge clk);
         guard++;
         if (!core_stall) begin
            ex_issue = 1'b0; ex_tbit = 1'b1; nmi_req = 1'b0;
         end
      end
      chk("R2 ld_valid with stall drop", ld_valid, 1'b1);
      chk("R2 sp from first word", sp_init, SP_WORD);
      chk("R2 pc from second word", pc_init, PC_WORD);
      chk("R1 two reads", addr_log.size(), 2);
      if (addr_log.size() == 2) begin
         chk("R1 first address", addr_log[0], 32'h0);
         chk("R1 second address", addr_log[1], 32'h4);
      end
      chk("R1 request cycles", req_cycles, 4);
      @(negedge clk);
      chk("R2 ld_valid one cycle", ld_valid, 1'b0);
      chk("R4 status untouched while stalled", fsr, 3'b000);

      // R7 fresh escalation, R5 invalid state
      exp_q.push_back(3);
      flt(1'b0, 1'b0);
      chk("R5 R7 invstate and forced", fsr, 3'b110);
      chk("R7 no lockup", lockup, 1'b0);

      // R8 fault in hard fault handler
      flt(1'b1, 1'b1);
      chk("R8 lockup entered", lockup, 1'b1);
      flt(1'b0, 1'b0);
      chk("R9 lockup held", lockup, 1'b1);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
      chk("R9 retire clears lockup", lockup, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);

      // R11 clear, R6 usage fault, R7 escalation from usage handler
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111);
      chk("R11 clear all", fsr, 3'b000);
      exp_q.push_back(6);
      flt(1'b1, 1'b1);
      chk("R5 R6 undef flag only", fsr, 3'b001);
      exp_q.push_back(3);
      flt(1'b1, 1'b1);
      chk("R7 forced after usage handler fault", fsr, 3'b101);
      flt(1'b1, 1'b1);
      chk("R8 lockup from hard handler", lockup, 1'b1);
      exp_q.push_back(2);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
      chk("R10 NMI clears lockup", lockup, 1'b0);
      flt(1'b0, 1'b0);
      chk("R8 lockup from NMI handler", lockup, 1'b1);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
      chk("R10 NMI inside NMI ignored", lockup, 1'b1);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
      chk("R9 retire clears lockup again", lockup, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);

      // R10 NMI wins over same-cycle fault
      exp_q.push_back(2);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
      chk("R10 no lockup after NMI with fault", lockup, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);

      // R11 set wins over clear, partial clear
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111);
      exp_q.push_back(6);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001);
      chk("R11 set beats clear", fsr, 3'b001);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b100);
      chk("R11 partial clear keeps bit0", fsr, 3'b001);

      // R12 exception return then usage fault again
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
      exp_q.push_back(6);
      flt(1'b0, 1'b0);
      chk("R12 usage after return, invstate", fsr, 3'b011);
      exp_q.push_back(3);
      flt(1'b1, 1'b1);
      flt(1'b1, 1'b1);
      chk("R8 locked before reset", lockup, 1'b1);

      // R3 debugger override across reset; R9 reset clears lockup
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R9 reset clears lockup", lockup, 1'b0);
      req_cycles = 0;
      addr_log.delete();
      dbg_wr = 1'b1; dbg_sp = DBG_SPV; dbg_pc = DBG_PCV; dbg_keep = 1'b1;
      @(negedge clk);
      dbg_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R3 stalled in release cycle", core_stall, 1'b1);
      @(negedge clk);
      chk("R3 stall drops after one cycle", core_stall, 1'b0);
      chk("R3 ld_valid pulse", ld_valid, 1'b1);
      chk("R3 debugger sp kept", sp_init, DBG_SPV);
      chk("R3 debugger pc kept", pc_init, DBG_PCV);
      chk("R3 no vector read", req_cycles, 0);
      chk("R11 status cleared by reset", fsr, 3'b000);
      exp_q.push_back(3);
      flt(1'b0, 1'b0);
      chk("R7 fresh escalation after reset", fsr, 3'b110);
      dbg_keep = 1'b0;

      repeat (3) @(negedge clk);
      chk("R6 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule